// File: doc/BRIEF.md
# Replay FIFO with Marked Restart Point

This block is a single-clock first-in first-out buffer that can hand the same stretch of stored data out more than once. A typical user is a filter engine that has to walk one sequence of coefficients or samples several times. Words go in through a valid/ready write handshake. Words come out through a valid/ready read handshake, and the oldest unread word is always shown on the read data port.

Replay is controlled by three inputs. A mode input turns replay on. While replay is on, a mark pulse records the word at the current read position as the start of the sequence to be replayed. A retransmit pulse then moves the read position back to that recorded word, so the replay can start from any logical location and not only from the first storage slot. While replay is on, every word from the recorded start onward is protected: the buffer reports full as soon as one more write would overwrite the oldest protected word. Turning the mode off releases that protection, and the full flag again counts only the unread words.

Top module: `fifo_rt`

## Requirements
- R1: After reset the buffer holds no words. `empty_o` is 1, `full_o` is 0, `rd_valid_o` is 0 and `wr_ready_o` is 1.
- R2: A write is accepted in a cycle where `wr_valid_i` and `wr_ready_o` are both 1. A read is taken in a cycle where `rd_valid_o` and `rd_ready_i` are both 1. Words leave in the order they were accepted, and whenever `rd_valid_o` is 1, `rd_data_o` shows the oldest unread word.
- R3: With replay off, `full_o` is 1 exactly when DEPTH words are unread, and `wr_ready_o` is its inverse. A write offered while full is dropped and does not change the stored sequence.
- R4: `empty_o` is 1 exactly when no unread word remains, and `rd_valid_o` is its inverse. A read request while empty moves nothing.
- R5: With replay on, `full_o` is 1 exactly when DEPTH words lie from the marked word up to the newest word. Reading past the mark does not free space, and writes offered in that state are dropped.
- R6: A retransmit pulse with replay on moves the read position to the marked word. From the next cycle `rd_data_o` shows that word, and `empty_o` is 0 whenever any word lies between the mark and the newest word.
- R7: A mark pulse with replay on records the current read position. If mark and retransmit arrive in the same cycle, the retransmit wins and the previously recorded mark is kept.
- R8: When retransmit (with replay on) and a read request arrive in the same cycle, the read is not taken.
- R9: A retransmit pulse with replay off is ignored, and a read requested in the same cycle is taken normally.
- R10: While replay is off, the recorded mark follows the read position, so turning replay on protects the data from the current read position. Turning replay off frees the protected words in that same cycle, and `full_o` is again computed from the unread words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| wr_ready_o | output | 1 | Write can be accepted |
| rd_valid_o | output | 1 | An unread word is present |
| rd_data_o | output | DATA_W | Oldest unread word |
| rd_ready_i | input | 1 | Read request |
| mark_i | input | 1 | Record current read position as replay start |
| retx_i | input | 1 | Return read position to the recorded start |
| replay_en_i | input | 1 | Replay mode on: protect data from the mark onward |
| full_o | output | 1 | No room for a write |
| empty_o | output | 1 | No unread word |

## Verification
The bench fills the buffer while replay is on, reads part of the data and then offers more writes. A design that measured fullness from the read position would accept those writes and corrupt the sequence that is to be replayed. It sends retransmit together with a read, and mark together with retransmit. A design with the wrong priority would skip the first replayed word or move the restart point. It also sends retransmit with replay off, where a design that honoured it would repeat stale data. Finally it turns replay off while the buffer is held full, where a design that kept the protection would go on refusing writes that now have room.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    // Per-cycle actions decided from the handshakes and control pulses.
    typedef struct packed {
        logic push;       // write accepted
        logic pop;        // read taken
        logic rewind;     // read position returns to mark
        logic take_mark;  // mark register loads read position
    } fifo_cmd_t;

    // Distance from tail to head on a ring whose pointers are pw bits wide.
    function automatic int unsigned ring_span(input int unsigned head,
                                              input int unsigned tail,
                                              input int unsigned pw);
        return (head - tail) & ((32'd1 << pw) - 32'd1);
    endfunction

    // Rewind beats a read and a mark; nothing moves past a full or empty edge.
    function automatic fifo_cmd_t decode_cmd(input logic wr_valid,
                                             input logic full,
                                             input logic rd_ready,
                                             input logic empty,
                                             input logic retx,
                                             input logic mode,
                                             input logic mark);
        fifo_cmd_t c;
        c.rewind    = retx & mode;
        c.push      = wr_valid & ~full;
        c.pop       = rd_ready & ~empty & ~c.rewind;
        c.take_mark = mark & mode & ~c.rewind;
        return c;
    endfunction

endpackage

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_rt_wrside.sv
module fifo_rt_wrside #(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    output logic [ADDR_W:0] wr_ptr
);
    localparam int PW = ADDR_W + 1;

    always_ff @(posedge clk) begin
        if (rst)       wr_ptr <= '0;
        else if (push) wr_ptr <= wr_ptr + PW'(1);
    end
endmodule

// File: rtl/fifo_rt_rdside.sv
module fifo_rt_rdside #(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pop,
    input  logic            rewind,
    input  logic            take_mark,
    input  logic            mode,
    output logic [ADDR_W:0] rd_ptr,
    output logic [ADDR_W:0] mark_ptr
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rd_next;
    logic [PW-1:0] mark_next;

    always_comb begin
        if (rewind)   rd_next = mark_ptr;
        else if (pop) rd_next = rd_ptr + PW'(1);
        else          rd_next = rd_ptr;

        // Outside replay the mark shadows the read position.
        if (!mode)          mark_next = rd_next;
        else if (take_mark) mark_next = rd_ptr;
        else                mark_next = mark_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            mark_ptr <= '0;
        end else begin
            rd_ptr   <= rd_next;
            mark_ptr <= mark_next;
        end
    end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wr_ready_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              rd_ready_i,
    input  logic              mark_i,
    input  logic              retx_i,
    input  logic              replay_en_i,
    output logic              full_o,
    output logic              empty_o
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] mark_ptr;
    logic [PW-1:0] guard_ptr;
    fifo_cmd_t     cmd;

    // The oldest word that must survive: the mark in replay, else the read position.
    assign guard_ptr  = replay_en_i ? mark_ptr : rd_ptr;
    assign full_o     = ring_span(32'(wr_ptr), 32'(guard_ptr), 32'(PW)) >= 32'(DEPTH);
    assign empty_o    = (wr_ptr == rd_ptr);
    assign wr_ready_o = ~full_o;
    assign rd_valid_o = ~empty_o;

    assign cmd = decode_cmd(wr_valid_i, full_o, rd_ready_i, empty_o,
                            retx_i, replay_en_i, mark_i);

    fifo_rt_wrside #(.ADDR_W(ADDR_W)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .push   (cmd.push),
        .wr_ptr (wr_ptr)
    );

    fifo_rt_rdside #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .pop       (cmd.pop),
        .rewind    (cmd.rewind),
        .take_mark (cmd.take_mark),
        .mode      (replay_en_i),
        .rd_ptr    (rd_ptr),
        .mark_ptr  (mark_ptr)
    );

    fifo_rt_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (cmd.push),
        .waddr (wr_ptr[ADDR_W-1:0]),
        .wdata (wr_data_i),
        .raddr (rd_ptr[ADDR_W-1:0]),
        .rdata (rd_data_o)
    );
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
    parameter int ADDR_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_valid_i,
    input logic            rd_ready_i,
    input logic            retx_i,
    input logic            replay_en_i,
    input logic            full_o,
    input logic            empty_o,
    input logic [ADDR_W:0] wr_ptr,
    input logic [ADDR_W:0] rd_ptr,
    input logic [ADDR_W:0] mark_ptr
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] unread;
    logic [PW-1:0] kept;
    assign unread = wr_ptr - rd_ptr;
    assign kept   = wr_ptr - mark_ptr;

    p_unread_bound_r2: assert property (@(posedge clk) disable iff (rst)
        unread <= PW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        full_o && wr_valid_i |=> $stable(wr_ptr));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        empty_o && !(retx_i && replay_en_i) |=> $stable(rd_ptr));

    p_kept_bound_r5: assert property (@(posedge clk) disable iff (rst)
        replay_en_i |-> kept <= PW'(DEPTH));

    p_rewind_target_r6: assert property (@(posedge clk) disable iff (rst)
        retx_i && replay_en_i |=> rd_ptr == $past(mark_ptr));

    p_retx_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        retx_i && !replay_en_i && !rd_ready_i |=> $stable(rd_ptr));

    p_mark_follows_r10: assert property (@(posedge clk) disable iff (rst)
        !replay_en_i |=> mark_ptr == rd_ptr);
endmodule

bind fifo_rt fifo_rt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_valid_i  (wr_valid_i),
    .rd_ready_i  (rd_ready_i),
    .retx_i      (retx_i),
    .replay_en_i (replay_en_i),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .mark_ptr    (mark_ptr)
);

// File: tb/fifo_rt_tb.sv
module fifo_rt_tb;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid_i = 1'b0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic              wr_ready_o;
    logic              rd_valid_o;
    logic [DATA_W-1:0] rd_data_o;
    logic              rd_ready_i = 1'b0;
    logic              mark_i = 1'b0;
    logic              retx_i = 1'b0;
    logic              replay_en_i = 1'b0;
    logic              full_o;
    logic              empty_o;

    always #10 clk = ~clk;

    fifo_rt #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (.*);

    int checks = 0;
    int fails  = 0;

    // Scoreboard: every accepted word is logged by absolute index.
    logic [DATA_W-1:0] hist [1024];
    int wc = 0, rc = 0, mc = 0;
    int seed = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic wv, input logic rr, input logic mk,
                        input logic rt, input logic md, input string tag);
        logic [DATA_W-1:0] wd;
        logic exp_full, exp_empty, push, pop, rew;
        int rc_n;
        seed++;
        wd = DATA_W'(seed * 16'h3b1 + 16'h55);
        @(negedge clk);
        wr_valid_i = wv; wr_data_i = wd; rd_ready_i = rr;
        mark_i = mk; retx_i = rt; replay_en_i = md;
        #1;
        exp_full  = md ? (wc - mc) >= DEPTH : (wc - rc) >= DEPTH;
        exp_empty = (wc == rc);
        chk(tag, "full", int'(full_o), int'(exp_full));
        chk(tag, "wr_ready", int'(wr_ready_o), int'(!exp_full));
        chk(tag, "empty", int'(empty_o), int'(exp_empty));
        chk(tag, "rd_valid", int'(rd_valid_o), int'(!exp_empty));
        if (!exp_empty) chk(tag, "rd_data", int'(rd_data_o), int'(hist[rc]));
        @(posedge clk);
        rew  = rt && md;
        push = wv && !exp_full;
        pop  = rr && !exp_empty && !rew;
        if (push) begin hist[wc] = wd; wc++; end
        rc_n = rew ? mc : rc + (pop ? 1 : 0);
        if (!md)            mc = rc_n;
        else if (mk && !rew) mc = rc;
        rc = rc_n;
    endtask

    task automatic wr_n(input int n, input logic md, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, md, tag);
    endtask

    task automatic rd_n(input int n, input logic md, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1'b0, md, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        // R1: reset state
        chk("R1", "empty", int'(empty_o), 1);
        chk("R1", "full", int'(full_o), 0);
        chk("R1", "rd_valid", int'(rd_valid_o), 0);
        chk("R1", "wr_ready", int'(wr_ready_o), 1);

        // R2: ordering, interleaved and simultaneous traffic
        wr_n(5, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        rd_n(6, 1'b0, "R2");

        // R4: read on empty moves nothing
        rd_n(2, 1'b0, "R4");

        // R3: fill without replay, then overflow attempts
        wr_n(DEPTH, 1'b0, "R3");
        wr_n(2, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        rd_n(DEPTH, 1'b0, "R3");

        // R7/R6: mark mid-stream and replay from there
        wr_n(6, 1'b1, "R7");
        rd_n(1, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
        rd_n(3, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
        rd_n(5, 1'b1, "R6");
        // R6: empty drops after rewind
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");

        // R8: rewind together with read, read not taken
        rd_n(2, 1'b1, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
        rd_n(2, 1'b1, "R8");

        // R7: mark with rewind keeps the old mark
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
        rd_n(2, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        rd_n(5, 1'b1, "R7");

        // R10: leaving replay, then re-enter with mark at read position
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");

        // R5: protection while reading past the mark
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        wr_n(DEPTH, 1'b1, "R5");
        rd_n(4, 1'b1, "R5");
        wr_n(2, 1'b1, "R5");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        // R10: dropping replay frees space at once
        wr_n(2, 1'b0, "R10");
        wr_n(3, 1'b0, "R10");

        // R9: rewind request outside replay is ignored
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        rd_n(DEPTH, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");

        finish_run();
    end
endmodule